// File: doc/BRIEF.md
# Predicated Floating-Point Maximum Reduction

This block reduces a packed 256-bit vector of floating-point lanes to one scalar maximum. A two-bit size code selects the lane format: half, single or double precision, which gives 16, 8 or 4 lanes. Each lane has a predicate bit. A lane whose bit is clear takes part as negative infinity, so it can never win against real data.

The lanes are combined as a balanced binary tree. At each level, adjacent pairs are merged, with the lower-indexed side always taken as the first operand, until a single value remains. Two mode inputs steer the pairwise comparator. The alternate mode returns the second operand whenever a NaN is involved or both inputs are zeros. The default-NaN mode replaces propagated NaNs with one fixed encoding. The scalar result is zero-extended to 64 bits and registered. A reserved size code raises a flag instead of producing a value.

Top module: `fp_max_reduce`

## Requirements
- R1: `size_i` selects the lane format: 2'b01 gives 16 half lanes (16 bits each), 2'b10 gives 8 single lanes (32 bits each), 2'b11 gives 4 double lanes (64 bits each). Lane k occupies `vec_i[k*W +: W]` and is gated by `pred_i[k]`. The result is the maximum of the active lanes, zero-extended into the 64-bit `result_o`.
- R2: An inactive lane contributes negative infinity, whatever its data, including NaN. When no lane of the selected format is active, the result is negative infinity: 16'hFC00, 32'hFF800000 or 64'hFFF0000000000000.
- R3: `size_i` = 2'b00 is reserved. It sets `illegal_o` to 1 and `result_o` to 0. Every other code clears `illegal_o`.
- R4: With `alt_i` = 0, negative zero orders below positive zero, so a max over -0 and +0 gives +0 in either lane order.
- R5: With `alt_i` = 0 and `dnan_i` = 0, a pair containing a NaN gives that NaN with its top fraction bit set. If both are NaN, the first operand is used. So the lowest-indexed NaN in tree order reaches the output.
- R6: With `alt_i` = 0 and `dnan_i` = 1, a pair containing a NaN gives the default NaN. This is positive, with the exponent all ones, the top fraction bit set and the other fraction bits clear: 16'h7E00, 32'h7FC00000 or 64'h7FF8000000000000.
- R7: With `alt_i` = 1, a pair of zeros of any signs gives the second (higher-indexed) operand.
- R8: With `alt_i` = 1, a pair in which either input is a NaN gives the second operand unchanged, whatever `dnan_i` is.
- R9: The reduction is a balanced pairwise tree. Level 1 combines lanes (0,1), (2,3) and so on. Each further level combines adjacent results of the level below, lower index first. It is not a left-to-right scan.
- R10: `result_o` and `illegal_o` are registered. They reflect the inputs present at the previous rising clock edge. A synchronous active-high `rst` clears both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_i | input | 256 | Packed source lanes |
| pred_i | input | 16 | Per-lane active bits; bit k gates lane k |
| size_i | input | 2 | Lane format code |
| alt_i | input | 1 | Alternate zero/NaN handling |
| dnan_i | input | 1 | Default-NaN output select |
| result_o | output | 64 | Zero-extended scalar maximum |
| illegal_o | output | 1 | Reserved size code seen |

## Verification
A fault in the comparator or in the tree wiring shows at `result_o` one clock after the inputs. It appears either as the wrong winner or as the wrong member of a tie or NaN pair. To expose these faults, the vectors use signed-zero pairs, NaN placement that makes a linear scan and the tree disagree, and signalling versus quiet NaN payloads. A masking fault shows as a masked NaN or a masked large value leaking through, or as an all-inactive vector giving anything other than negative infinity. A wrong decode of the size code shows as a misplaced `illegal_o` or as non-zero upper result bits on the same cycle.

// File: rtl/fmr_pkg.sv
package fmr_pkg;

    typedef enum logic [1:0] {
        SZ_RSVD   = 2'b00,
        SZ_HALF   = 2'b01,
        SZ_SINGLE = 2'b10,
        SZ_DOUBLE = 2'b11
    } lane_size_e;

    typedef struct packed {
        logic alt_mode;
        logic dnan_mode;
    } cmp_mode_t;

    typedef struct packed {
        logic [63:0] value;
        logic        illegal;
    } red_out_t;

    localparam int HALF_W   = 16;
    localparam int SINGLE_W = 32;
    localparam int DOUBLE_W = 64;

    // exponent field width for a lane width
    function automatic int exp_bits(input int w);
        if (w == HALF_W)   return 5;
        if (w == SINGLE_W) return 8;
        return 11;
    endfunction

endpackage

// File: rtl/fmr_max2.sv
module fmr_max2
    import fmr_pkg::*;
#(
    parameter int W = 32,
    parameter int E = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  cmp_mode_t    mode_i,
    output logic [W-1:0] y_o
);

    localparam int F = W - E - 1;
    localparam logic [W-1:0] QBIT = {{(E+1){1'b0}}, 1'b1, {(F-1){1'b0}}};
    localparam logic [W-1:0] DNAN = {1'b0, {E{1'b1}}, 1'b1, {(F-1){1'b0}}};

    typedef struct packed {
        logic nan;
        logic zero;
    } cls_t;

    function automatic cls_t classify(input logic [W-1:0] v);
        cls_t c;
        c.nan  = (&v[W-2:F]) && (|v[F-1:0]);
        c.zero = ~|v[W-2:0];
        return c;
    endfunction

    // maps sign-magnitude onto an unsigned total order
    function automatic logic [W-1:0] order_key(input logic [W-1:0] v);
        return v[W-1] ? ~v : {1'b1, v[W-2:0]};
    endfunction

    cls_t ca, cb;

    always_comb begin
        ca = classify(a_i);
        cb = classify(b_i);
        if (mode_i.alt_mode && (ca.nan || cb.nan || (ca.zero && cb.zero))) begin
            y_o = b_i;
        end else if (ca.nan || cb.nan) begin
            if (mode_i.dnan_mode)
                y_o = DNAN;
            else
                y_o = ca.nan ? (a_i | QBIT) : (b_i | QBIT);
        end else begin
            y_o = (order_key(a_i) >= order_key(b_i)) ? a_i : b_i;
        end
    end

endmodule

// File: rtl/fmr_tree.sv
module fmr_tree
    import fmr_pkg::*;
#(
    parameter int W = 32,
    parameter int E = 8,
    parameter int N = 8
) (
    input  logic [N*W-1:0] lanes_i,
    input  logic [N-1:0]   act_i,
    input  cmp_mode_t      mode_i,
    output logic [W-1:0]   root_o
);

    localparam int L = $clog2(N);
    localparam logic [W-1:0] NEG_INF = {1'b1, {E{1'b1}}, {(W-E-1){1'b0}}};

    for (genvar l = 0; l <= L; l++) begin : g_lvl
        logic [(N>>l)*W-1:0] v;
        if (l == 0) begin : g_leaf
            for (genvar k = 0; k < N; k++) begin : g_mask
                assign v[k*W +: W] = act_i[k] ? lanes_i[k*W +: W] : NEG_INF;
            end
        end else begin : g_node
            for (genvar j = 0; j < (N >> l); j++) begin : g_pair
                fmr_max2 #(.W(W), .E(E)) u_cmp (
                    .a_i    (g_lvl[l-1].v[(2*j)*W +: W]),
                    .b_i    (g_lvl[l-1].v[(2*j+1)*W +: W]),
                    .mode_i (mode_i),
                    .y_o    (v[j*W +: W])
                );
            end
        end
    end

    assign root_o = g_lvl[L].v;

endmodule

// File: rtl/fp_max_reduce.sv
module fp_max_reduce
    import fmr_pkg::*;
#(
    parameter int VEC_W = 256,
    parameter int OUT_W = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [VEC_W-1:0]   vec_i,
    input  logic [VEC_W/16-1:0] pred_i,
    input  logic [1:0]         size_i,
    input  logic               alt_i,
    input  logic               dnan_i,
    output logic [OUT_W-1:0]   result_o,
    output logic               illegal_o
);

    localparam int N_H = VEC_W / HALF_W;
    localparam int N_S = VEC_W / SINGLE_W;
    localparam int N_D = VEC_W / DOUBLE_W;
    localparam int E_H = exp_bits(HALF_W);
    localparam int E_S = exp_bits(SINGLE_W);
    localparam int E_D = exp_bits(DOUBLE_W);

    cmp_mode_t mode;
    assign mode = '{alt_mode: alt_i, dnan_mode: dnan_i};

    logic [HALF_W-1:0]   r_h;
    logic [SINGLE_W-1:0] r_s;
    logic [DOUBLE_W-1:0] r_d;

    fmr_tree #(.W(HALF_W), .E(E_H), .N(N_H)) u_half (
        .lanes_i (vec_i),
        .act_i   (pred_i[N_H-1:0]),
        .mode_i  (mode),
        .root_o  (r_h)
    );

    fmr_tree #(.W(SINGLE_W), .E(E_S), .N(N_S)) u_single (
        .lanes_i (vec_i),
        .act_i   (pred_i[N_S-1:0]),
        .mode_i  (mode),
        .root_o  (r_s)
    );

    fmr_tree #(.W(DOUBLE_W), .E(E_D), .N(N_D)) u_double (
        .lanes_i (vec_i),
        .act_i   (pred_i[N_D-1:0]),
        .mode_i  (mode),
        .root_o  (r_d)
    );

    red_out_t nxt;

    always_comb begin
        nxt = '0;
        unique case (lane_size_e'(size_i))
            SZ_HALF:   nxt.value = 64'(r_h);
            SZ_SINGLE: nxt.value = 64'(r_s);
            SZ_DOUBLE: nxt.value = r_d;
            default:   nxt.illegal = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o  <= '0;
            illegal_o <= 1'b0;
        end else begin
            result_o  <= OUT_W'(nxt.value);
            illegal_o <= nxt.illegal;
        end
    end

    // R3: reserved size code flags and zeroes the result
    a_r3_reserved_flag: assert property (@(posedge clk) disable iff (rst)
        (size_i == 2'b00) |=> (illegal_o && result_o == '0));

    // R3: legal codes never flag
    a_r3_legal_clear: assert property (@(posedge clk) disable iff (rst)
        (size_i != 2'b00) |=> !illegal_o);

    // R1: half result is zero-extended
    a_r1_half_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (size_i == 2'b01) |=> (result_o[OUT_W-1:HALF_W] == '0));

    // R2: no active single lane yields negative infinity
    a_r2_none_active: assert property (@(posedge clk) disable iff (rst)
        (size_i == 2'b10 && pred_i[N_S-1:0] == '0) |=> (result_o == OUT_W'(32'hFF80_0000)));

    // R5: propagated double NaN is quiet
    a_r5_quiet_nan: assert property (@(posedge clk) disable iff (rst)
        (size_i == 2'b11 && !alt_i && !dnan_i) |=>
        (result_o[62:52] != 11'h7FF || result_o[51:0] == '0 || result_o[51]));

    // R6: double NaN output is the default encoding
    a_r6_default_nan: assert property (@(posedge clk) disable iff (rst)
        (size_i == 2'b11 && !alt_i && dnan_i) |=>
        (result_o[62:52] != 11'h7FF || result_o[51:0] == '0 ||
         result_o == 64'h7FF8_0000_0000_0000));

    // R10: reset clears the registered outputs
    a_r10_reset_clear: assert property (@(posedge clk)
        rst |=> (result_o == '0 && !illegal_o));

endmodule

// File: tb/fp_max_reduce_tb.sv
module fp_max_reduce_tb;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic [255:0] vec_i;
    logic [15:0]  pred_i;
    logic [1:0]   size_i;
    logic         alt_i;
    logic         dnan_i;
    logic [63:0]  result_o;
    logic         illegal_o;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_max_reduce u_dut (
        .clk       (clk),
        .rst       (rst),
        .vec_i     (vec_i),
        .pred_i    (pred_i),
        .size_i    (size_i),
        .alt_i     (alt_i),
        .dnan_i    (dnan_i),
        .result_o  (result_o),
        .illegal_o (illegal_o)
    );

    typedef struct packed {
        logic [1:0]   size;
        logic         alt;
        logic         dn;
        logic [15:0]  pred;
        logic [255:0] vec;
        logic [63:0]  exp;
        logic         ill;
    } row_t;

    localparam logic [31:0] ONE = 32'h3F80_0000;
    localparam logic [255:0] V_MIX = {32'h40A00000, 32'hC1000000, 32'h3F000000, 32'h41000000,
                                      32'h40800000, 32'hC0400000, 32'h40000000, 32'h3F800000};
    localparam logic [255:0] V_HALF = {{6{16'hBC00}}, 16'h4000, {9{16'hBC00}}};
    localparam logic [255:0] V_DBL = {64'hFFF0000000000000, 64'h4008000000000000,
                                      64'h3FF0000000000000, 64'hC000000000000000};
    localparam logic [255:0] V_DNAN = {64'h3FF0000000000000, 64'h3FF0000000000000,
                                       64'h7FF0000000000001, 64'h3FF0000000000000};

    localparam int NV = 22;
    localparam row_t TBL [NV] = '{
        '{2'b10, 1'b0, 1'b0, 16'h00FF, V_MIX, 64'h41000000, 1'b0},                              // R1
        '{2'b10, 1'b0, 1'b0, 16'h00EF, V_MIX, 64'h40A00000, 1'b0},                              // R2
        '{2'b10, 1'b0, 1'b0, 16'hFF00, V_MIX, 64'hFF800000, 1'b0},                              // R2
        '{2'b10, 1'b0, 1'b0, 16'h00F7, {{4{ONE}}, 32'h7F800001, {3{ONE}}}, 64'h3F800000, 1'b0}, // R2
        '{2'b01, 1'b0, 1'b0, 16'hFFFF, V_HALF, 64'h4000, 1'b0},                                 // R1
        '{2'b11, 1'b0, 1'b0, 16'h000F, V_DBL, 64'h4008000000000000, 1'b0},                      // R1
        '{2'b11, 1'b0, 1'b0, 16'h000B, V_DBL, 64'h3FF0000000000000, 1'b0},                      // R2
        '{2'b00, 1'b0, 1'b0, 16'hFFFF, V_MIX, 64'h0, 1'b1},                                     // R3
        '{2'b10, 1'b0, 1'b0, 16'h0003, {{6{ONE}}, 32'h00000000, 32'h80000000}, 64'h0, 1'b0},    // R4
        '{2'b10, 1'b0, 1'b0, 16'h0003, {{6{ONE}}, 32'h80000000, 32'h00000000}, 64'h0, 1'b0},    // R4
        '{2'b10, 1'b1, 1'b0, 16'h0003, {{6{ONE}}, 32'h80000000, 32'h00000000}, 64'h80000000, 1'b0}, // R7
        '{2'b10, 1'b1, 1'b0, 16'h0003, {{6{ONE}}, 32'h00000000, 32'h80000000}, 64'h0, 1'b0},    // R7
        '{2'b10, 1'b1, 1'b1, 16'h0003, {{6{ONE}}, 32'h40A00000, 32'h7F800001}, 64'h40A00000, 1'b0}, // R8
        '{2'b10, 1'b0, 1'b0, 16'h0003, {{6{ONE}}, 32'h40A00000, 32'h7F800001}, 64'h7FC00001, 1'b0}, // R5
        '{2'b10, 1'b0, 1'b1, 16'h0003, {{6{ONE}}, 32'h40A00000, 32'h7F800001}, 64'h7FC00000, 1'b0}, // R6
        '{2'b10, 1'b1, 1'b0, 16'h0003, {{6{ONE}}, 32'h7F800001, 32'h40A00000}, 64'hFF800000, 1'b0}, // R8
        '{2'b10, 1'b1, 1'b0, 16'h000F, {{4{ONE}}, 32'h40000000, 32'h7FC00000, ONE, 32'h40A00000},
          64'h40A00000, 1'b0},                                                                  // R9
        '{2'b10, 1'b0, 1'b0, 16'h00FF, {{2{ONE}}, 32'h7FC00007, {2{ONE}}, 32'h7F800005, {2{ONE}}},
          64'h7FC00005, 1'b0},                                                                  // R5
        '{2'b01, 1'b0, 1'b1, 16'hFFFF, {{15{16'hBC00}}, 16'h7C01}, 64'h7E00, 1'b0},             // R6
        '{2'b11, 1'b0, 1'b1, 16'h000F, V_DNAN, 64'h7FF8000000000000, 1'b0},                     // R6
        '{2'b11, 1'b0, 1'b0, 16'h000F, V_DNAN, 64'h7FF8000000000001, 1'b0},                     // R5
        '{2'b01, 1'b0, 1'b0, 16'h0000, V_HALF, 64'hFC00, 1'b0}                                  // R2
    };

    function automatic string row_tag(input int i);
        case (i)
            0, 4, 5:              return "R1 max of active lanes";
            1, 2, 3, 6, 21:       return "R2 inactive lanes as -inf";
            7:                    return "R3 reserved size";
            8, 9:                 return "R4 signed zero order";
            10, 11:               return "R7 alt zeros give second";
            12, 15:               return "R8 alt NaN gives second";
            13, 17, 20:           return "R5 quiet first NaN";
            14, 18, 19:           return "R6 default NaN";
            default:              return "R9 pairwise tree order";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act_v, input logic [63:0] exp_v,
                         input logic act_f, input logic exp_f);
        n_run++;
        if (act_v !== exp_v || act_f !== exp_f) begin
            n_fail++;
            $display("FAIL %s: actual result=%h illegal=%b expected result=%h illegal=%b",
                     tag, act_v, act_f, exp_v, exp_f);
        end
    endtask

    task automatic drive(input row_t r);
        size_i = r.size;
        alt_i  = r.alt;
        dnan_i = r.dn;
        pred_i = r.pred;
        vec_i  = r.vec;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL R10 watchdog: actual=no finish expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(TBL[0]);
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset state", result_o, 64'h0, illegal_o, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TBL[i]);
            @(posedge clk);
            #1;
            check(row_tag(i), result_o, TBL[i].exp, illegal_o, TBL[i].ill);
        end

        // R10: output holds until the next edge, then follows
        @(negedge clk);
        drive(TBL[0]);
        @(posedge clk);
        #1;
        @(negedge clk);
        drive(TBL[1]);
        #1;
        check("R10 held before edge", result_o, 64'h41000000, illegal_o, 1'b0);
        @(posedge clk);
        #1;
        check("R10 updates after edge", result_o, 64'h40A00000, illegal_o, 1'b0);

        // R3: flag clears again on a legal size
        @(negedge clk);
        drive(TBL[7]);
        @(posedge clk);
        #1;
        check("R3 flag set", result_o, 64'h0, illegal_o, 1'b1);
        @(negedge clk);
        drive(TBL[4]);
        @(posedge clk);
        #1;
        check("R3 flag cleared", result_o, 64'h4000, illegal_o, 1'b0);

        // R10: synchronous reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R10 mid-run reset", result_o, 64'h0, illegal_o, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule